// File: doc/BRIEF.md
# Packed Byte-Lane Vector Adder Coprocessor

This block is a small coprocessor that a processor core drives through a custom-instruction command path. Each command brings two 64-bit source operands and the 32-bit instruction word. The block treats each operand as a vector of 8-bit lanes. It adds the two vectors lane by lane, with no carry crossing from one lane into the next, and returns the packed 64-bit sum on a response path. The response also carries the destination register index, which the block takes from the instruction word.

Both the command path and the response path use a valid/ready handshake. When the block accepts a command, it stores the command in a register and computes the lanes from that stored copy. Its operand inputs are therefore free to change while a result waits. The block holds one command at a time. A busy flag stays high for the whole time a command is outstanding, so the core knows when a fence may complete.

Top module: `lane_vec_cop`

## Requirements
- R1: The lanes are little-endian. Lane i occupies bits 8i+7 down to 8i of each operand and of the result, so lane 0 sits in bits 7:0 and lane 7 sits in bits 63:56.
- R2: Each result lane equals the sum of the matching operand lanes modulo 256. No carry passes into the neighbouring lane. For example, 0xFF plus 0x01 gives 0x00 in that lane and leaves every other lane unchanged.
- R3: The operands and the instruction word are captured on the clock edge that accepts the command. Changes on `cmd_rs1`, `cmd_rs2` and `cmd_inst` after that edge have no effect on the pending response.
- R4: `rsp_rd` equals bits 11:7 of the accepted instruction word.
- R5: `cmd_ready` is high only while no command is outstanding. A command offered while a response is pending is not taken until that response completes.
- R6: `rsp_valid` goes high in the cycle after a command is accepted. It stays high, with `rsp_data` and `rsp_rd` held stable, until a cycle in which `rsp_ready` is high.
- R7: `busy` goes high on the accepting edge. It stays high through the cycle in which the response handshake completes, and it is low after that edge.
- R8: While `rst_n` is low the block is idle: `cmd_ready` is high, and `rsp_valid` and `busy` are low. This also holds when reset arrives with a response pending; that response is dropped.
- R9: The block can accept a new command in the cycle right after a response handshake completes.
- R10: An operand of 0x0F0D0B0907050301 added to itself gives 0x1E1A16120E0A0602.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_inst | input | 32 | Instruction word; bits 11:7 hold the destination index |
| cmd_rs1 | input | 64 | First source operand |
| cmd_rs2 | input | 64 | Second source operand |
| rsp_valid | output | 1 | A result is waiting |
| rsp_ready | input | 1 | The core takes the result |
| rsp_rd | output | 5 | Destination register index of the result |
| rsp_data | output | 64 | Packed lane-wise sum |
| busy | output | 1 | A command is outstanding |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- Lane overflow: values such as 0xFF + 0x01 and 0x80 + 0x80 in every lane catch a design that lets carries cross lanes. Such a design puts stray ones into the upper lanes.
- Lane order: a word with distinct lane values plus zero catches a design with reversed lane order, which returns a byte-swapped result.
- Operand capture: the bench scrambles the operand and instruction inputs straight after acceptance. This catches a design that computes from the live inputs, which returns a garbage sum or index.
- Back-pressure: the bench holds `rsp_ready` low while it offers a second command. This catches a design that overwrites a pending result or drops busy too early, which would corrupt or lose a response.
- Reset: a reset with a response pending checks that the block returns to idle.

// File: rtl/lane_vec_pkg.sv
package lane_vec_pkg;

  // Controller state: waiting for a command, or holding a result for the core.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } cop_state_e;

endpackage

// File: rtl/lane_vec_hold.sv
// Capture register for one accepted command: both operands and the rd field.
module lane_vec_hold #(
  parameter int DATA_W = 64,
  parameter int INST_W = 32,
  parameter int RD_W   = 5,
  parameter int RD_LSB = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [INST_W-1:0] inst_in,
  input  logic [DATA_W-1:0] src_a_in,
  input  logic [DATA_W-1:0] src_b_in,
  output logic [DATA_W-1:0] src_a_q,
  output logic [DATA_W-1:0] src_b_q,
  output logic [RD_W-1:0]   rd_q
);

  logic [DATA_W-1:0] src_a_d;
  logic [DATA_W-1:0] src_b_d;
  logic [RD_W-1:0]   rd_d;

  // Next-state: load on accept, otherwise hold.
  always_comb begin
    src_a_d = src_a_q;
    src_b_d = src_b_q;
    rd_d    = rd_q;
    if (load_en) begin
      src_a_d = src_a_in;
      src_b_d = src_b_in;
      rd_d    = inst_in[RD_LSB +: RD_W];
    end
  end

  // Wide data path: no reset, enable written out.
  always_ff @(posedge clk) begin
    if (load_en) begin
      src_a_q <= src_a_d;
      src_b_q <= src_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (load_en) begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/lane_vec_sum.sv
// Lane-wise adder: each lane wraps on its own, with no carry between lanes.
module lane_vec_sum #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] vec_a,
  input  logic [LANES*LANE_W-1:0] vec_b,
  output logic [LANES*LANE_W-1:0] vec_sum
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_a;
    logic [LANE_W-1:0] lane_b;
    logic [LANE_W-1:0] lane_s;
    assign lane_a = vec_a[g*LANE_W +: LANE_W];
    assign lane_b = vec_b[g*LANE_W +: LANE_W];
    assign lane_s = lane_a + lane_b;
    assign vec_sum[g*LANE_W +: LANE_W] = lane_s;
  end

endmodule

// File: rtl/lane_vec_ctrl.sv
// Single-entry handshake controller.
module lane_vec_ctrl
  import lane_vec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic rsp_ready,
  output logic cmd_ready,
  output logic rsp_valid,
  output logic busy,
  output logic load_en
);

  cop_state_e state_q;
  cop_state_e state_d;
  logic       take_cmd;
  logic       give_rsp;

  assign take_cmd = cmd_valid && (state_q == ST_IDLE);
  assign give_rsp = rsp_ready && (state_q == ST_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_cmd) state_d = ST_HOLD;
      ST_HOLD: if (give_rsp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_HOLD);
  assign busy      = (state_q != ST_IDLE);
  assign load_en   = take_cmd;

endmodule

// File: rtl/lane_vec_cop.sv
// Top level: packed byte-lane vector adder behind a command/response handshake.
module lane_vec_cop #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int INST_W = 32,
  parameter int RD_W   = 5,
  parameter int RD_LSB = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [INST_W-1:0]       cmd_inst,
  input  logic [LANES*LANE_W-1:0] cmd_rs1,
  input  logic [LANES*LANE_W-1:0] cmd_rs2,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [RD_W-1:0]         rsp_rd,
  output logic [LANES*LANE_W-1:0] rsp_data,
  output logic                    busy
);

  localparam int DATA_W = LANES * LANE_W;

  logic              load_en;
  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;

  lane_vec_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .rsp_ready (rsp_ready),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .load_en   (load_en)
  );

  lane_vec_hold #(
    .DATA_W (DATA_W),
    .INST_W (INST_W),
    .RD_W   (RD_W),
    .RD_LSB (RD_LSB)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .inst_in  (cmd_inst),
    .src_a_in (cmd_rs1),
    .src_b_in (cmd_rs2),
    .src_a_q  (held_a),
    .src_b_q  (held_b),
    .rd_q     (rsp_rd)
  );

  lane_vec_sum #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_sum (
    .vec_a   (held_a),
    .vec_b   (held_b),
    .vec_sum (rsp_data)
  );

endmodule

// File: rtl/lane_vec_cop_chk.sv
// Property checker, attached to the top by bind.
module lane_vec_cop_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int INST_W = 32,
  parameter int RD_W   = 5,
  parameter int RD_LSB = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [INST_W-1:0]       cmd_inst,
  input logic [LANES*LANE_W-1:0] cmd_rs1,
  input logic [LANES*LANE_W-1:0] cmd_rs2,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [RD_W-1:0]         rsp_rd,
  input logic [LANES*LANE_W-1:0] rsp_data,
  input logic                    busy
);

  localparam int DATA_W = LANES * LANE_W;

  function automatic logic [DATA_W-1:0] ref_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  logic acc;
  logic done;
  assign acc  = cmd_valid && cmd_ready;
  assign done = rsp_valid && rsp_ready;

  p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_data == ref_sum($past(cmd_rs1), $past(cmd_rs2)));

  p_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_data[LANE_W-1:0] ==
            LANE_W'($past(cmd_rs1[LANE_W-1:0]) + $past(cmd_rs2[LANE_W-1:0])));

  p_rd_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_rd == $past(cmd_inst[RD_LSB +: RD_W]));

  p_no_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  p_rsp_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_rd));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && cmd_ready);

endmodule

bind lane_vec_cop lane_vec_cop_chk #(
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .INST_W (INST_W),
  .RD_W   (RD_W),
  .RD_LSB (RD_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_inst  (cmd_inst),
  .cmd_rs1   (cmd_rs1),
  .cmd_rs2   (cmd_rs2),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rd    (rsp_rd),
  .rsp_data  (rsp_data),
  .busy      (busy)
);

// File: tb/lane_vec_cop_test.sv
module lane_vec_cop_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_inst = '0;
  logic [63:0] cmd_rs1 = '0;
  logic [63:0] cmd_rs2 = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [4:0]  rsp_rd;
  logic [63:0] rsp_data;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit after_done = 0;
  bit ended = 0;
  logic [68:0] exp_q[$];

  lane_vec_cop uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_inst  (cmd_inst),
    .cmd_rs1   (cmd_rs1),
    .cmd_rs2   (cmd_rs2),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rd    (rsp_rd),
    .rsp_data  (rsp_data),
    .busy      (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] lane_ref(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*i +: 8] + b[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Response-ready pattern, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0:       rsp_ready = 1'b1;
      1:       rsp_ready = cyc[0] ^ cyc[2];
      default: rsp_ready = 1'b0;
    endcase
  end

  // Scoreboard monitor: compares each completed response with the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      if (after_done) begin
        after_done = 0;
        chk("R7 busy low after handshake", 64'(busy), 64'd0);
        chk("R9 ready after handshake", 64'(cmd_ready), 64'd1);
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected response", 64'(1), 64'(0));
        end else begin
          logic [68:0] e;
          e = exp_q.pop_front();
          chk("R2 rsp_data", rsp_data, e[63:0]);
          chk("R4 rsp_rd", 64'(rsp_rd), 64'(e[68:64]));
        end
        after_done = 1;
      end
    end
  end

  // Driver: offers one command, then scrambles inputs to prove capture (R3).
  task automatic send_cmd(input logic [4:0] rd, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] inst;
    inst = {7'h2A, 5'h13, 5'h0C, 3'h5, rd, 7'h0B};
    exp_q.push_back({rd, lane_ref(a, b)});
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_inst  = inst;
    cmd_rs1   = a;
    cmd_rs2   = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_inst  = ~inst;
    cmd_rs1   = ~a;
    cmd_rs2   = a ^ b ^ 64'h5A5A_A5A5_3C3C_C3C3;
    chk("R6 rsp_valid after accept", 64'(rsp_valid), 64'd1);
    chk("R7 busy after accept", 64'(busy), 64'd1);
    chk("R5 ready low while pending", 64'(cmd_ready), 64'd0);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R6 all responses delivered", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8 reset busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 known vector, R1 lane order, R2 wrap cases, R4 rd extremes.
    rdy_mode = 0;
    send_cmd(5'd31, 64'h0F0D0B0907050301, 64'h0F0D0B0907050301);
    @(negedge clk);
    chk("R10 doubled vector", lane_ref(64'h0F0D0B0907050301, 64'h0F0D0B0907050301),
        64'h1E1A16120E0A0602);
    send_cmd(5'd0,  64'h0102030405060708, 64'h0);
    send_cmd(5'd1,  64'h00000000000000FF, 64'h0000000000000001);
    send_cmd(5'd17, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101);
    send_cmd(5'd9,  64'h8080808080808080, 64'h8080808080808080);
    send_cmd(5'd22, 64'hFF00000000000000, 64'h0100000000000000);
    drain();

    // Irregular back-pressure.
    rdy_mode = 1;
    for (int k = 0; k < 12; k++) begin
      send_cmd(5'(k * 7 + 3), {8{8'(k * 37 + 11)}} ^ 64'(k * 64'h1234_5678_9ABC),
               64'hF0E1D2C3B4A59687 + 64'(k * 977));
    end
    drain();

    // R5: a second command waits while the first result is refused.
    rdy_mode = 2;
    send_cmd(5'd5, 64'h1111111111111111, 64'h2222222222222222);
    fork
      send_cmd(5'd6, 64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101);
      begin
        repeat (5) begin
          @(negedge clk);
          chk("R5 no accept while pending", 64'(cmd_ready), 64'd0);
          chk("R6 rsp_valid held", 64'(rsp_valid), 64'd1);
          chk("R6 rsp_data held", rsp_data, 64'h3333333333333333);
        end
        rdy_mode = 0;
      end
    join
    drain();

    // R8: reset with a response pending drops it.
    rdy_mode = 2;
    send_cmd(5'd12, 64'hDEADBEEFCAFEF00D, 64'h0123456789ABCDEF);
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    #1;
    chk("R8 mid-run reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8 mid-run reset busy", 64'(busy), 64'd0);
    chk("R8 mid-run reset cmd_ready", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    rdy_mode = 0;
    send_cmd(5'd3, 64'h00FF00FF00FF00FF, 64'h0001000100010001);
    drain();

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule